// File: doc/BRIEF.md
# Branch Target and Condition Unit

This unit resolves one branch instruction per clock. It recognises four branch forms: an immediate form with a 24-bit word displacement, a conditional form with a 14-bit word displacement, and two register-indirect forms that jump through the link register or the count register. For each branch it produces the target address and the taken decision. It also produces the return address with a write strobe for the link register, and the decremented count with a write strobe for the count register.

The caller presents the instruction word with the current PC and the present condition, count and link register values, and raises `in_valid_i`. The results appear registered on the next clock edge with `out_valid_o`. The unit does no fetching and no flushing. It only computes what a fetch stage or a register write-back stage needs.

The 5-bit option field (called BO here, bits 25:21) controls the conditional forms. It can enable a count decrement followed by a zero or non-zero test. It can enable a test of one condition-register bit, chosen by the 5-bit selector field BI (bits 20:16), with a selectable sense. The two tests combine into the taken decision.

Top module: `bt_unit`

## Requirements
- R1: The form is decoded from bits 31:26. A value of 18 is the immediate form and 16 is the conditional form. A value of 19 is the link-indirect form when bits 10:1 equal 16, and the count-indirect form when bits 10:1 equal 528. Every other word gives `is_branch_o`=0, and `taken_o`, `link_we_o` and `ctr_we_o` stay 0.
- R2: In the immediate form, the displacement is bits 25:2 followed by two zero bits, sign-extended from bit 25.
- R3: In the conditional form, the displacement is bits 15:2 followed by two zero bits, sign-extended from bit 15.
- R4: In the immediate and conditional forms, bit 1 set makes the displacement itself the target. With bit 1 clear, the target is PC plus the displacement, modulo 2^ADDR_W.
- R5: When bit 0 of a branch is set, `link_we_o`=1 and `link_addr_o` equals PC+4, whether or not the branch is taken.
- R6: The immediate form is always taken. A conditional form whose BO has both bit 4 and bit 2 set (BO AND 10100b equal to 10100b) is taken regardless of the count and condition inputs.
- R7: In the conditional and link-indirect forms, BO bit 2 clear causes `ctr_we_o`=1 with `ctr_next_o` = count−1 (wrapping). The count test then passes when BO bit 1 is set and the new count is zero, or when BO bit 1 is clear and the new count is non-zero.
- R8: With BO bit 4 clear, the condition bit at position 31−(4·BI[4:2]+BI[1:0]) of `cr_i` is tested. Bit 31 is the most significant bit. The test passes when that bit equals BO bit 3.
- R9: A conditional or indirect branch is taken only when both the count test and the condition test pass. A test that is disabled counts as passing.
- R10: The link-indirect target is `lr_i` with bits 1:0 cleared. The count-indirect target is `ctr_i` with bits 1:0 cleared.
- R11: The count-indirect form never decrements (`ctr_we_o`=0), and its count test always passes.
- R12: Results appear one clock after `in_valid_i` is sampled high. While `out_valid_o` is 0, `taken_o`, `link_we_o` and `ctr_we_o` are 0. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Instruction and operands are valid |
| instr_i | input | 32 | Instruction word |
| pc_i | input | ADDR_W | Address of the instruction |
| cr_i | input | 32 | Condition register |
| ctr_i | input | ADDR_W | Count register |
| lr_i | input | ADDR_W | Link register |
| out_valid_o | output | 1 | Registered results are valid |
| is_branch_o | output | 1 | The word was one of the four branch forms |
| taken_o | output | 1 | Branch is taken |
| target_o | output | ADDR_W | Branch target address |
| link_we_o | output | 1 | Write the return address to the link register |
| link_addr_o | output | ADDR_W | Return address (PC+4) |
| ctr_we_o | output | 1 | Write the decremented count |
| ctr_next_o | output | ADDR_W | Decremented count value |

## Verification
The bench builds the unit with the default ADDR_W of 32. At this width, sign extension from bit 25 and from bit 15 fills a visible span of upper bits. Relative targets wrap below address zero, and a count of zero wraps to all ones, so each of these cases can be checked against a hand-computed literal. The selector cases cover the first and last condition bits and a neighbouring bit, which exposes any error in the bit-order mapping.

// File: rtl/bt_pkg.sv
package bt_pkg;

    localparam int CR_W = 32;

    localparam logic [5:0] OPC_IMM  = 6'd18;
    localparam logic [5:0] OPC_COND = 6'd16;
    localparam logic [5:0] OPC_REG  = 6'd19;
    localparam logic [9:0] XO_LINK  = 10'd16;
    localparam logic [9:0] XO_COUNT = 10'd528;

    typedef enum logic [2:0] {
        FORM_NONE,
        FORM_IMM,
        FORM_COND,
        FORM_LINK,
        FORM_COUNT
    } form_e;

    typedef struct packed {
        form_e      form;
        logic [4:0] bo;
        logic [4:0] bi;
        logic       absolute;
        logic       link;
    } dec_t;

endpackage

// File: rtl/bt_decode.sv
module bt_decode
    import bt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [31:0]       instr_i,
    output dec_t              dec_o,
    output logic [ADDR_W-1:0] disp_o
);

    localparam int IMM_W  = 26;
    localparam int COND_W = 16;

    logic [5:0]        opcode;
    logic [9:0]        xo;
    logic [ADDR_W-1:0] disp_imm;
    logic [ADDR_W-1:0] disp_cond;

    assign opcode = instr_i[31:26];
    assign xo     = instr_i[10:1];

    generate
        if (ADDR_W > IMM_W) begin : g_wide
            assign disp_imm  = {{(ADDR_W-IMM_W){instr_i[25]}}, instr_i[25:2], 2'b00};
            assign disp_cond = {{(ADDR_W-COND_W){instr_i[15]}}, instr_i[15:2], 2'b00};
        end else begin : g_narrow
            assign disp_imm  = ADDR_W'({instr_i[25:2], 2'b00});
            assign disp_cond = {{(ADDR_W-COND_W){instr_i[15]}}, instr_i[15:2], 2'b00};
        end
    endgenerate

    always_comb begin
        dec_o          = '0;
        dec_o.form     = FORM_NONE;
        dec_o.bo       = instr_i[25:21];
        dec_o.bi       = instr_i[20:16];
        dec_o.absolute = instr_i[1];
        dec_o.link     = instr_i[0];
        disp_o         = '0;
        unique case (opcode)
            OPC_IMM: begin
                dec_o.form = FORM_IMM;
                disp_o     = disp_imm;
            end
            OPC_COND: begin
                dec_o.form = FORM_COND;
                disp_o     = disp_cond;
            end
            OPC_REG: begin
                if (xo == XO_LINK) begin
                    dec_o.form = FORM_LINK;
                end else if (xo == XO_COUNT) begin
                    dec_o.form = FORM_COUNT;
                end
                dec_o.absolute = 1'b0;
            end
            default: begin
                dec_o.form = FORM_NONE;
            end
        endcase
    end

endmodule

// File: rtl/bt_cond.sv
module bt_cond
    import bt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  dec_t              dec_i,
    input  logic [CR_W-1:0]   cr_i,
    input  logic [ADDR_W-1:0] ctr_i,
    output logic              taken_o,
    output logic              ctr_we_o,
    output logic [ADDR_W-1:0] ctr_next_o
);

    localparam logic [4:0] CR_TOP = 5'(CR_W - 1);

    logic       is_cond_like;
    logic       use_count;
    logic       use_cr;
    logic       count_zero;
    logic       count_ok;
    logic       cr_ok;
    logic [2:0] cr_field;
    logic [1:0] cr_pos;
    logic [4:0] cr_index;
    logic       cr_bit;

    assign is_cond_like = (dec_i.form == FORM_COND) || (dec_i.form == FORM_LINK)
                       || (dec_i.form == FORM_COUNT);

    // count decrement allowed only in conditional and link-indirect forms
    assign use_count  = ((dec_i.form == FORM_COND) || (dec_i.form == FORM_LINK)) && !dec_i.bo[2];
    assign ctr_next_o = ctr_i - ADDR_W'(1);
    assign count_zero = (ctr_next_o == '0);
    assign count_ok   = !use_count || (count_zero == dec_i.bo[1]);

    assign cr_field = dec_i.bi[4:2];
    assign cr_pos   = dec_i.bi[1:0];
    assign cr_index = CR_TOP - {cr_field, cr_pos};
    assign cr_bit   = cr_i[cr_index];
    assign use_cr   = is_cond_like && !dec_i.bo[4];
    assign cr_ok    = !use_cr || (cr_bit == dec_i.bo[3]);

    assign ctr_we_o = use_count;

    always_comb begin
        unique case (dec_i.form)
            FORM_IMM:   taken_o = 1'b1;
            FORM_COND,
            FORM_LINK,
            FORM_COUNT: taken_o = count_ok && cr_ok;
            default:    taken_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/bt_target.sv
module bt_target
    import bt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  dec_t              dec_i,
    input  logic [ADDR_W-1:0] disp_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] lr_i,
    input  logic [ADDR_W-1:0] ctr_i,
    output logic [ADDR_W-1:0] target_o
);

    logic [ADDR_W-1:0] rel_target;
    logic [ADDR_W-1:0] imm_target;

    assign rel_target = pc_i + disp_i;
    assign imm_target = dec_i.absolute ? disp_i : rel_target;

    always_comb begin
        unique case (dec_i.form)
            FORM_IMM,
            FORM_COND:  target_o = imm_target;
            FORM_LINK:  target_o = {lr_i[ADDR_W-1:2], 2'b00};
            FORM_COUNT: target_o = {ctr_i[ADDR_W-1:2], 2'b00};
            default:    target_o = '0;
        endcase
    end

endmodule

// File: rtl/bt_unit.sv
module bt_unit
    import bt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid_i,
    input  logic [31:0]       instr_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [31:0]       cr_i,
    input  logic [ADDR_W-1:0] ctr_i,
    input  logic [ADDR_W-1:0] lr_i,
    output logic              out_valid_o,
    output logic              is_branch_o,
    output logic              taken_o,
    output logic [ADDR_W-1:0] target_o,
    output logic              link_we_o,
    output logic [ADDR_W-1:0] link_addr_o,
    output logic              ctr_we_o,
    output logic [ADDR_W-1:0] ctr_next_o
);

    localparam logic [ADDR_W-1:0] INSTR_BYTES = ADDR_W'(4);

    typedef struct packed {
        logic              vld;
        logic              is_br;
        logic              taken;
        logic [ADDR_W-1:0] target;
        logic              link_we;
        logic [ADDR_W-1:0] link_addr;
        logic              ctr_we;
        logic [ADDR_W-1:0] ctr_next;
    } out_t;

    dec_t              dec_w;
    logic [ADDR_W-1:0] disp_w;
    logic              taken_w;
    logic              ctr_we_w;
    logic [ADDR_W-1:0] ctr_next_w;
    logic [ADDR_W-1:0] target_w;
    logic              is_br_w;
    out_t              st_d;
    out_t              st_q;

    bt_decode #(.ADDR_W(ADDR_W)) decode_i (
        .instr_i (instr_i),
        .dec_o   (dec_w),
        .disp_o  (disp_w)
    );

    bt_cond #(.ADDR_W(ADDR_W)) cond_i (
        .dec_i      (dec_w),
        .cr_i       (cr_i),
        .ctr_i      (ctr_i),
        .taken_o    (taken_w),
        .ctr_we_o   (ctr_we_w),
        .ctr_next_o (ctr_next_w)
    );

    bt_target #(.ADDR_W(ADDR_W)) target_i (
        .dec_i    (dec_w),
        .disp_i   (disp_w),
        .pc_i     (pc_i),
        .lr_i     (lr_i),
        .ctr_i    (ctr_i),
        .target_o (target_w)
    );

    assign is_br_w = (dec_w.form != FORM_NONE);

    always_comb begin
        st_d         = st_q;
        st_d.vld     = in_valid_i;
        st_d.taken   = 1'b0;
        st_d.link_we = 1'b0;
        st_d.ctr_we  = 1'b0;
        if (in_valid_i) begin
            st_d.is_br     = is_br_w;
            st_d.taken     = is_br_w && taken_w;
            st_d.target    = target_w;
            st_d.link_we   = is_br_w && dec_w.link;
            st_d.link_addr = pc_i + INSTR_BYTES;
            st_d.ctr_we    = is_br_w && ctr_we_w;
            st_d.ctr_next  = ctr_next_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid_o = st_q.vld;
    assign is_branch_o = st_q.is_br;
    assign taken_o     = st_q.taken;
    assign target_o    = st_q.target;
    assign link_we_o   = st_q.link_we;
    assign link_addr_o = st_q.link_addr;
    assign ctr_we_o    = st_q.ctr_we;
    assign ctr_next_o  = st_q.ctr_next;

endmodule

// File: rtl/bt_unit_chk.sv
module bt_unit_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid_i,
    input logic [31:0]       instr_i,
    input logic [ADDR_W-1:0] pc_i,
    input logic [ADDR_W-1:0] ctr_i,
    input logic              out_valid_o,
    input logic              is_branch_o,
    input logic              taken_o,
    input logic [ADDR_W-1:0] target_o,
    input logic              link_we_o,
    input logic [ADDR_W-1:0] link_addr_o,
    input logic              ctr_we_o,
    input logic [ADDR_W-1:0] ctr_next_o
);

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid_o |-> (!taken_o && !link_we_o && !ctr_we_o));

    // R12
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> out_valid_o);

    // R1
    nonbranch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !is_branch_o) |-> (!taken_o && !link_we_o && !ctr_we_o));

    // R5
    return_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && instr_i[0] && instr_i[31:26] == 6'd18) |=>
            (link_we_o && link_addr_o == $past(pc_i) + ADDR_W'(4)));

    // R7
    ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && instr_i[31:26] == 6'd16 && !instr_i[23]) |=>
            (ctr_we_o && ctr_next_o == $past(ctr_i) - ADDR_W'(1)));

    // R6
    imm_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && instr_i[31:26] == 6'd18) |=> taken_o);

    // R10
    indirect_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && instr_i[31:26] == 6'd19) |=> (target_o[1:0] == 2'b00));

    // R11
    count_form_no_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && instr_i[31:26] == 6'd19 && instr_i[10:1] == 10'd528) |=> !ctr_we_o);

endmodule

bind bt_unit bt_unit_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid_i  (in_valid_i),
    .instr_i     (instr_i),
    .pc_i        (pc_i),
    .ctr_i       (ctr_i),
    .out_valid_o (out_valid_o),
    .is_branch_o (is_branch_o),
    .taken_o     (taken_o),
    .target_o    (target_o),
    .link_we_o   (link_we_o),
    .link_addr_o (link_addr_o),
    .ctr_we_o    (ctr_we_o),
    .ctr_next_o  (ctr_next_o)
);

// File: tb/bt_unit_tb_top.sv
module bt_unit_tb_top;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid_i = 1'b0;
    logic [31:0]   instr_i = '0;
    logic [AW-1:0] pc_i = '0;
    logic [31:0]   cr_i = '0;
    logic [AW-1:0] ctr_i = '0;
    logic [AW-1:0] lr_i = '0;
    logic          out_valid_o;
    logic          is_branch_o;
    logic          taken_o;
    logic [AW-1:0] target_o;
    logic          link_we_o;
    logic [AW-1:0] link_addr_o;
    logic          ctr_we_o;
    logic [AW-1:0] ctr_next_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    bt_unit #(.ADDR_W(AW)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid_i  (in_valid_i),
        .instr_i     (instr_i),
        .pc_i        (pc_i),
        .cr_i        (cr_i),
        .ctr_i       (ctr_i),
        .lr_i        (lr_i),
        .out_valid_o (out_valid_o),
        .is_branch_o (is_branch_o),
        .taken_o     (taken_o),
        .target_o    (target_o),
        .link_we_o   (link_we_o),
        .link_addr_o (link_addr_o),
        .ctr_we_o    (ctr_we_o),
        .ctr_next_o  (ctr_next_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_imm(logic [23:0] li, logic aa, logic lk);
        return {6'd18, li, aa, lk};
    endfunction

    function automatic logic [31:0] mk_cond(logic [4:0] bo, logic [4:0] bi, logic [13:0] bd,
                                            logic aa, logic lk);
        return {6'd16, bo, bi, bd, aa, lk};
    endfunction

    function automatic logic [31:0] mk_reg(logic [4:0] bo, logic [4:0] bi, logic [9:0] xo, logic lk);
        return {6'd19, bo, bi, 5'd0, xo, lk};
    endfunction

    // issue one word at a falling edge; results are sampled one cycle later at the next falling edge
    task automatic issue(input logic [31:0] ins, input logic [AW-1:0] pc, input logic [31:0] cr,
                         input logic [AW-1:0] ctr, input logic [AW-1:0] lr);
        in_valid_i = 1'b1;
        instr_i    = ins;
        pc_i       = pc;
        cr_i       = cr;
        ctr_i      = ctr;
        lr_i       = lr;
        @(negedge clk);
        in_valid_i = 1'b0;
    endtask

    task automatic t_reset;
        chk("R12 reset valid", 64'(out_valid_o), 64'd0);
        chk("R12 reset taken", 64'(taken_o), 64'd0);
        chk("R12 reset target", 64'(target_o), 64'd0);
        chk("R12 reset ctr_we", 64'(ctr_we_o), 64'd0);
    endtask

    task automatic t_imm;
        issue(mk_imm(24'h000040, 1'b0, 1'b0), 32'h1000, '0, 32'd7, '0);
        chk("R2 imm fwd target", 64'(target_o), 64'h1100);
        chk("R6 imm taken", 64'(taken_o), 64'd1);
        chk("R1 imm is_branch", 64'(is_branch_o), 64'd1);
        chk("R5 imm no link", 64'(link_we_o), 64'd0);
        chk("R7 imm no ctr", 64'(ctr_we_o), 64'd0);
        issue(mk_imm(24'hFFFFFC, 1'b0, 1'b1), 32'h1000, '0, '0, '0);
        chk("R2 imm back target", 64'(target_o), 64'h0FF0);
        chk("R5 imm link_we", 64'(link_we_o), 64'd1);
        chk("R5 imm link addr", 64'(link_addr_o), 64'h1004);
        issue(mk_imm(24'h000200, 1'b1, 1'b0), 32'h1000, '0, '0, '0);
        chk("R4 imm absolute", 64'(target_o), 64'h800);
        issue(mk_imm(24'hFFFFFF, 1'b1, 1'b0), 32'h1000, '0, '0, '0);
        chk("R4 imm absolute neg", 64'(target_o), 64'hFFFF_FFFC);
        issue(mk_imm(24'hFFFFFC, 1'b0, 1'b0), 32'h0000_0008, '0, '0, '0);
        chk("R4 imm wrap", 64'(target_o), 64'hFFFF_FFF8);
    endtask

    task automatic t_cond_always;
        issue(mk_cond(5'b10100, 5'd5, 14'h3FFF, 1'b0, 1'b0), 32'h1000, '0, 32'd9, '0);
        chk("R3 cond back target", 64'(target_o), 64'h0FFC);
        chk("R6 cond always taken", 64'(taken_o), 64'd1);
        chk("R7 always no ctr", 64'(ctr_we_o), 64'd0);
        issue(mk_cond(5'b10100, 5'd0, 14'h0040, 1'b1, 1'b0), 32'h1000, '0, '0, '0);
        chk("R4 cond absolute", 64'(target_o), 64'h100);
    endtask

    task automatic t_cond_cr;
        // BI=5 -> field 1, bit 1 -> cr bit 26
        issue(mk_cond(5'b01100, 5'd5, 14'h0004, 1'b0, 1'b0), 32'h1000, 32'h0400_0000, '0, '0);
        chk("R8 cr set taken", 64'(taken_o), 64'd1);
        chk("R3 cond fwd target", 64'(target_o), 64'h1010);
        issue(mk_cond(5'b01100, 5'd5, 14'h0004, 1'b0, 1'b1), 32'h1000, 32'h0, '0, '0);
        chk("R8 cr clear not taken", 64'(taken_o), 64'd0);
        chk("R5 link when not taken", 64'(link_we_o), 64'd1);
        issue(mk_cond(5'b00100, 5'd5, 14'h0004, 1'b0, 1'b0), 32'h1000, 32'h0, '0, '0);
        chk("R8 sense clear taken", 64'(taken_o), 64'd1);
        issue(mk_cond(5'b00100, 5'd5, 14'h0004, 1'b0, 1'b0), 32'h1000, 32'h0400_0000, '0, '0);
        chk("R8 sense clear bit set", 64'(taken_o), 64'd0);
        issue(mk_cond(5'b01100, 5'd5, 14'h0004, 1'b0, 1'b0), 32'h1000, 32'h0800_0000, '0, '0);
        chk("R8 neighbour bit", 64'(taken_o), 64'd0);
        issue(mk_cond(5'b01100, 5'd31, 14'h0004, 1'b0, 1'b0), 32'h1000, 32'h0000_0001, '0, '0);
        chk("R8 last bit", 64'(taken_o), 64'd1);
        issue(mk_cond(5'b01100, 5'd0, 14'h0004, 1'b0, 1'b0), 32'h1000, 32'h7FFF_FFFF, '0, '0);
        chk("R8 first bit", 64'(taken_o), 64'd0);
    endtask

    task automatic t_count;
        issue(mk_cond(5'b10000, 5'd0, 14'h0004, 1'b0, 1'b0), 32'h1000, '0, 32'd5, '0);
        chk("R7 dec value", 64'(ctr_next_o), 64'd4);
        chk("R7 dec we", 64'(ctr_we_o), 64'd1);
        chk("R7 nonzero taken", 64'(taken_o), 64'd1);
        issue(mk_cond(5'b10000, 5'd0, 14'h0004, 1'b0, 1'b0), 32'h1000, '0, 32'd1, '0);
        chk("R7 reach zero not taken", 64'(taken_o), 64'd0);
        chk("R7 reach zero value", 64'(ctr_next_o), 64'd0);
        issue(mk_cond(5'b10010, 5'd0, 14'h0004, 1'b0, 1'b0), 32'h1000, '0, 32'd1, '0);
        chk("R7 zero sense taken", 64'(taken_o), 64'd1);
        issue(mk_cond(5'b10000, 5'd0, 14'h0004, 1'b0, 1'b0), 32'h1000, '0, 32'd0, '0);
        chk("R7 wrap value", 64'(ctr_next_o), 64'hFFFF_FFFF);
        chk("R7 wrap taken", 64'(taken_o), 64'd1);
    endtask

    task automatic t_combined;
        issue(mk_cond(5'b00000, 5'd5, 14'h0004, 1'b0, 1'b0), 32'h1000, 32'h0400_0000, 32'd3, '0);
        chk("R9 cr fails", 64'(taken_o), 64'd0);
        chk("R9 ctr still written", 64'(ctr_we_o), 64'd1);
        chk("R9 ctr value", 64'(ctr_next_o), 64'd2);
        issue(mk_cond(5'b00000, 5'd5, 14'h0004, 1'b0, 1'b0), 32'h1000, 32'h0, 32'd3, '0);
        chk("R9 both pass", 64'(taken_o), 64'd1);
        issue(mk_cond(5'b00000, 5'd5, 14'h0004, 1'b0, 1'b0), 32'h1000, 32'h0, 32'd1, '0);
        chk("R9 count fails", 64'(taken_o), 64'd0);
    endtask

    task automatic t_indirect;
        issue(mk_reg(5'b10100, 5'd0, 10'd16, 1'b1), 32'h1000, '0, 32'd5, 32'h2003);
        chk("R10 link target", 64'(target_o), 64'h2000);
        chk("R6 link taken", 64'(taken_o), 64'd1);
        chk("R5 link-indirect link", 64'(link_addr_o), 64'h1004);
        issue(mk_reg(5'b10010, 5'd0, 10'd16, 1'b0), 32'h1000, '0, 32'd1, 32'h2000);
        chk("R7 link-indirect dec", 64'(ctr_we_o), 64'd1);
        chk("R7 link-indirect taken", 64'(taken_o), 64'd1);
        issue(mk_reg(5'b10100, 5'd0, 10'd528, 1'b0), 32'h1000, '0, 32'h3007, '0);
        chk("R10 count target", 64'(target_o), 64'h3004);
        chk("R11 count no dec", 64'(ctr_we_o), 64'd0);
        issue(mk_reg(5'b10000, 5'd0, 10'd528, 1'b0), 32'h1000, '0, 32'd1, '0);
        chk("R11 count test passes", 64'(taken_o), 64'd1);
        chk("R11 count no dec 2", 64'(ctr_we_o), 64'd0);
    endtask

    task automatic t_nonbranch;
        issue({6'd14, 26'h0000001}, 32'h1000, '0, '0, '0);
        chk("R1 other opcode", 64'(is_branch_o), 64'd0);
        chk("R1 other no taken", 64'(taken_o), 64'd0);
        chk("R1 other no link", 64'(link_we_o), 64'd0);
        issue(mk_reg(5'b10000, 5'd0, 10'd150, 1'b1), 32'h1000, '0, 32'd5, '0);
        chk("R1 op19 other xo", 64'(is_branch_o), 64'd0);
        chk("R1 op19 no ctr", 64'(ctr_we_o), 64'd0);
        chk("R1 op19 no link", 64'(link_we_o), 64'd0);
    endtask

    task automatic t_idle;
        @(negedge clk);
        chk("R12 idle valid", 64'(out_valid_o), 64'd0);
        chk("R12 idle taken", 64'(taken_o), 64'd0);
        chk("R12 idle link", 64'(link_we_o), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_imm();
        t_cond_always();
        t_cond_cr();
        t_count();
        t_combined();
        t_indirect();
        t_nonbranch();
        t_idle();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule